// File: doc/BRIEF.md
# I2C Controller Interrupt Status and Vector Unit

This unit sits beside an I2C controller core and turns the core's one-cycle event pulses into sticky status flags. Software reads the flags, clears them by writing ones, and chooses through an enable mask which of them may raise the single interrupt line. A bus-busy level from the core is shown in the status word as a live mirror. It is not stored.

For software written against older parts, a vector register reports the most urgent pending event among the five basic ones as a small code. Reading that register clears the event it reported, so a handler can drain events one at a time by reading the vector until it returns zero.

The register port is a plain 16-bit bus with an address, a write strobe and a read strobe. Read data is combinational from the address, and all register updates take effect at the next rising clock edge.

Top module: `i2c_irq_status`

## Requirements
- R1: After reset, the enable and status registers are zero, the vector reads 0 and irq is low. The register map is: address 0 is enable, address 1 is status, address 2 is vector, and address 3 reads 0. rdata always shows the register selected by addr.
- R2: Each event pulse sets its status bit at the next edge. The bit positions are: arbitration lost 0, no-acknowledge 1, access ready 2, receive ready 3, transmit ready 4, address zero 8, addressed as slave 9, transmit underflow 10, receive overrun 11, receive draining 13, transmit draining 14.
- R3: A status write clears every bit written as 1 and leaves every bit written as 0 unchanged.
- R4: If an event pulse arrives in the same cycle as a clear of its bit (by a status write or a vector read), the bit stays set.
- R5: Only enable bits 0–4, 13 and 14 are writable. All other enable bits read 0.
- R6: irq is high exactly while the bitwise AND of the stored status and the enable register is nonzero.
- R7: The vector reads 0 when none of status bits 0–4 is set. Otherwise it reads the lowest set bit index plus 1: 1 arbitration lost, 2 no-acknowledge, 3 access ready, 4 receive ready, 5 transmit ready. It does not depend on the enable mask.
- R8: A read (rd_en high, addr 2) of a nonzero vector clears only the status bit it reported, at the next edge.
- R9: Status bit 12 always equals the bus_busy input. Writes do not change it, and it never raises irq.
- R10: Status bits 5–7 and 15 always read 0, and writes and events do not change them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Register address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (side effect on vector only) |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for addr |
| ev_arb_lost | input | 1 | Arbitration lost pulse |
| ev_nack | input | 1 | No-acknowledge pulse |
| ev_acc_rdy | input | 1 | Access ready pulse |
| ev_rx_rdy | input | 1 | Receive data ready pulse |
| ev_tx_rdy | input | 1 | Transmit data ready pulse |
| ev_gen_call | input | 1 | Address zero seen pulse |
| ev_slave_hit | input | 1 | Addressed as slave pulse |
| ev_tx_udf | input | 1 | Transmit underflow pulse |
| ev_rx_ovr | input | 1 | Receive overrun pulse |
| ev_rx_drain | input | 1 | Receive buffer draining pulse |
| ev_tx_drain | input | 1 | Transmit buffer draining pulse |
| bus_busy | input | 1 | Bus busy level |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a clear and a fresh event landing on the same bit in the same cycle. This matters for both clear paths, and most of all for a vector read, which clears a bit chosen by the design itself. Directed steps line up a pulse with a one-write to status and with a vector read of the bit that is pending. A long random phase then sends frequent pulses, writes and vector reads against a behavioural model, so that several-event orderings and collisions occur many times.

// File: rtl/i2c_irq_status.sv
module i2c_irq_status #(
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [15:0]       wdata,
  output logic [15:0]       rdata,
  input  logic              ev_arb_lost,
  input  logic              ev_nack,
  input  logic              ev_acc_rdy,
  input  logic              ev_rx_rdy,
  input  logic              ev_tx_rdy,
  input  logic              ev_gen_call,
  input  logic              ev_slave_hit,
  input  logic              ev_tx_udf,
  input  logic              ev_rx_ovr,
  input  logic              ev_rx_drain,
  input  logic              ev_tx_drain,
  input  logic              bus_busy,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_EN  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_VEC = ADDR_W'(2);
  localparam logic [15:0] STS_MASK = 16'h6F1F;
  localparam logic [15:0] EN_MASK  = 16'h601F;
  localparam int BUSY_BIT = 12;

  logic [15:0] sts, en_q, ev_bits, clr_bits, vec_clr;
  logic [2:0]  vec_code;

  assign ev_bits = {1'b0, ev_tx_drain, ev_rx_drain, 1'b0, ev_rx_ovr, ev_tx_udf,
                    ev_slave_hit, ev_gen_call, 3'b000, ev_tx_rdy, ev_rx_rdy,
                    ev_acc_rdy, ev_nack, ev_arb_lost};

  always_comb begin
    vec_code = 3'd0;
    for (int i = 4; i >= 0; i--)
      if (sts[i]) vec_code = 3'(i + 1);
  end

  always_comb begin
    vec_clr = '0;
    if (rd_en && addr == A_VEC && vec_code != 3'd0)
      vec_clr[vec_code - 3'd1] = 1'b1;
  end

  assign clr_bits = ((wr_en && addr == A_STS) ? wdata : 16'h0) | vec_clr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sts  <= '0;
      en_q <= '0;
    end else begin
      sts <= ((sts & ~clr_bits) | ev_bits) & STS_MASK;
      if (wr_en && addr == A_EN) en_q <= wdata & EN_MASK;
    end
  end

  always_comb begin
    case (addr)
      A_EN:    rdata = en_q;
      A_STS:   rdata = sts | (16'(bus_busy) << BUSY_BIT);
      A_VEC:   rdata = {13'd0, vec_code};
      default: rdata = 16'h0;
    endcase
  end

  assign irq = |(sts & en_q);
endmodule

module i2c_irq_status_chk #(
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic              rd_en,
  input logic [15:0]       wdata,
  input logic [15:0]       rdata,
  input logic              ev_arb_lost,
  input logic              bus_busy,
  input logic              irq,
  input logic [15:0]       sts,
  input logic [15:0]       en_q
);
  // R3
  w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(1) && wdata[0] && !ev_arb_lost) |=> !sts[0]);
  // R4
  event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_arb_lost |=> sts[0]);
  // R8
  vec_read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == ADDR_W'(2) && rdata == 16'd1 && !ev_arb_lost) |=> !sts[0]);
  // R9
  busy_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == ADDR_W'(1)) |-> (rdata[12] == bus_busy));
  // R10
  unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sts[7:5] == 3'b000) && !sts[15] && !sts[12]);
  // R6
  no_enable_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == 16'h0) |-> !irq);
endmodule

bind i2c_irq_status i2c_irq_status_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
  .wdata(wdata), .rdata(rdata), .ev_arb_lost(ev_arb_lost),
  .bus_busy(bus_busy), .irq(irq), .sts(sts), .en_q(en_q));

// File: tb/tb_i2c_irq_status.sv
module tb_i2c_irq_status;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic [1:0] addr = 0;
  logic wr_en = 0, rd_en = 0, bus_busy = 0;
  logic [15:0] wdata = 0;
  logic [10:0] ev = 0;
  logic [15:0] rdata;
  logic irq;
  int total = 0, bad = 0;

  // model state
  logic [15:0] m_sts = 0, m_en = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_irq_status dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata),
    .ev_arb_lost(ev[0]), .ev_nack(ev[1]), .ev_acc_rdy(ev[2]), .ev_rx_rdy(ev[3]),
    .ev_tx_rdy(ev[4]), .ev_gen_call(ev[5]), .ev_slave_hit(ev[6]),
    .ev_tx_udf(ev[7]), .ev_rx_ovr(ev[8]), .ev_rx_drain(ev[9]),
    .ev_tx_drain(ev[10]), .bus_busy(bus_busy), .irq(irq));

  function automatic logic [15:0] ev_pos(input logic [10:0] e);
    int pos[11] = '{0, 1, 2, 3, 4, 8, 9, 10, 11, 13, 14};
    logic [15:0] r = 0;
    for (int i = 0; i < 11; i++) if (e[i]) r[pos[i]] = 1'b1;
    return r;
  endfunction

  function automatic int m_vec();
    for (int i = 0; i < 5; i++) if (m_sts[i]) return i + 1;
    return 0;
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one bus cycle: drive, compare against model, advance model
  task automatic step(input logic [1:0] a, input logic w, input logic r,
                      input logic [15:0] d, input logic [10:0] e,
                      input logic b, input string tag);
    logic [15:0] exp_rd, clr;
    @(negedge clk);
    addr = a; wr_en = w; rd_en = r; wdata = d; ev = e; bus_busy = b;
    #1;
    case (a)
      2'd0: exp_rd = m_en;
      2'd1: exp_rd = m_sts | (16'(b) << 12);
      2'd2: exp_rd = 16'(m_vec());
      default: exp_rd = 0;
    endcase
    check(tag, rdata, exp_rd);
    check({tag, "/R6 irq"}, 16'(irq), 16'(|(m_sts & m_en)));
    clr = (w && a == 2'd1) ? d : 16'h0;
    if (r && a == 2'd2 && m_vec() != 0) clr[m_vec() - 1] = 1'b1;
    m_sts = (m_sts & ~clr) | ev_pos(e);
    if (w && a == 2'd0) m_en = d & 16'h601F;
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    bad++; total++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R1 reset state over all addresses
    for (int a = 0; a < 4; a++) step(2'(a), 0, 0, 0, 0, 0, "R1 reset");
    // R2 each event lands on its own bit
    for (int i = 0; i < 11; i++) begin
      step(2'd1, 0, 0, 0, 11'(1 << i), 0, "R2 event");
      step(2'd1, 0, 0, 0, 0, 0, "R2 readback");
      step(2'd1, 1, 0, 16'hFFFF, 0, 0, "R3 clear all");
    end
    // R3 write-one-to-clear, zero leaves
    step(2'd1, 0, 0, 0, 11'h7FF, 0, "R3 set all");
    step(2'd1, 1, 0, 16'h0000, 0, 0, "R3 write zeros");
    step(2'd1, 1, 0, 16'h0A05, 0, 0, "R3 partial clear");
    step(2'd1, 0, 0, 0, 0, 0, "R3 partial readback");
    // R4 collisions: write clear and vector read
    step(2'd1, 1, 0, 16'hFFFF, 11'h001, 0, "R4 write vs event");
    step(2'd1, 0, 0, 0, 0, 0, "R4 bit kept");
    step(2'd2, 0, 1, 0, 11'h001, 0, "R4 vec read vs event");
    step(2'd2, 0, 0, 0, 0, 0, "R4 vec kept");
    step(2'd1, 1, 0, 16'hFFFF, 0, 0, "R4 cleanup");
    // R5 enable writable bits
    step(2'd0, 1, 0, 16'hFFFF, 0, 0, "R5 write enable");
    step(2'd0, 0, 0, 0, 0, 0, "R5 enable readback");
    // R6 irq follows masked status
    step(2'd1, 0, 0, 0, 11'h020, 0, "R6 unmaskable event");
    step(2'd1, 0, 0, 0, 11'h004, 0, "R6 maskable event");
    step(2'd0, 1, 0, 16'h0000, 0, 0, "R6 mask off");
    step(2'd1, 1, 0, 16'hFFFF, 0, 0, "R6 clear");
    // R7/R8 vector priority and read-to-clear drain
    step(2'd2, 0, 0, 0, 11'h01F, 0, "R7 none yet");
    for (int k = 0; k < 6; k++) step(2'd2, 0, 1, 0, 0, 0, "R8 drain");
    step(2'd2, 0, 0, 0, 11'h018, 0, "R7 set 4,5");
    step(2'd2, 0, 0, 0, 11'h002, 0, "R7 lower arrives");
    step(2'd2, 0, 1, 0, 0, 0, "R8 read 2");
    step(2'd1, 0, 0, 0, 0, 0, "R8 only reported cleared");
    step(2'd1, 1, 0, 16'hFFFF, 0, 0, "R8 cleanup");
    // R9 busy mirror
    step(2'd1, 0, 0, 0, 0, 1, "R9 busy high");
    step(2'd1, 1, 0, 16'h1000, 0, 1, "R9 clear attempt");
    step(2'd1, 0, 0, 0, 0, 1, "R9 still high");
    step(2'd1, 0, 0, 0, 0, 0, "R9 busy low");
    // R10 unused bits
    step(2'd0, 1, 0, 16'hFFFF, 0, 0, "R10 enable all");
    step(2'd1, 1, 0, 16'h80E0, 0, 0, "R10 unused write");
    step(2'd1, 0, 0, 0, 0, 0, "R10 unused zero");
    step(2'd3, 1, 0, 16'hFFFF, 0, 0, "R10 address 3");
    // random phase
    for (int n = 0; n < 4000; n++) begin
      logic [1:0] a = 2'($urandom_range(0, 3));
      logic [15:0] d = 16'($urandom);
      logic [10:0] e = 11'($urandom) & 11'($urandom);
      step(a, ($urandom_range(0, 3) == 0), ($urandom_range(0, 2) == 0), d, e,
           1'($urandom), "R7 random");
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule